// File: doc/BRIEF.md
# DS1 Frame and Superframe Timing Generator

This block produces the frame and superframe timing of a T1 (DS1) framer. A one-cycle bit enable, arriving once per 1.544 MHz bit period, advances a bit counter that spans 193 bit positions per frame. Each wrap of that counter advances a frame counter through a superframe of 12 frames (D4 framing) or 24 frames (extended superframe framing). An 8 kHz frame strobe marks the framing-bit position of every frame. A 4 kHz data-link strobe marks the framing bit of odd frames in extended mode.

The superframe normally runs free. A falling edge on the active-low realignment input makes the next frame frame 1 of a fresh superframe. A superframe-start output pulses during the last bit of a superframe to announce that frame 1 follows, but only while the receiver reports that it is synchronized. A framing mode selected on the mode input is adopted only at a superframe boundary. The surrounding framer uses the indices to place framing bits, signalling and link data.

Top module: `ds1_frame_timer`

## Requirements
- R1: When rst_n is low at a clock edge, bit_index becomes 0, frame_index becomes 1, realignment is not pending and the frame length becomes 12. With bit_en low, all strobes are 0.
- R2: bit_index advances by one on each clock with bit_en high and wraps from 192 to 0. It does not change while bit_en is low. frame_strobe equals bit_en while bit_index is 0, which gives one strobe every 193 bit enables.
- R3: With the D4 length in force (esf_mode low at the last boundary), frame_index counts 1 to 12. It goes to 1 at the bit_index 192 to 0 wrap that follows frame 12, so a superframe is 12 × 193 bit enables.
- R4: With the extended length in force (esf_mode high at the last boundary), frame_index counts 1 to 24, so a superframe is 24 × 193 bit enables.
- R5: esf_mode is sampled only at the wrap that moves frame_index to 1. A change made between boundaries does not alter the current superframe's length. If the frame index is at or beyond the length in force, the next frame is 1.
- R6: sf_start_pulse is high in exactly the bit-enabled cycle with bit_index 192 after which frame_index becomes 1, provided rx_sync_valid is high.
- R7: While rx_sync_valid is low, sf_start_pulse stays 0 and the counters keep running and wrapping.
- R8: A high-to-low transition of tx_sf_n makes the next frame frame 1. Keeping tx_sf_n low across further frame boundaries causes no additional realignment.
- R9: fdl_strobe is high only when frame_strobe is high, the extended length is in force and frame_index is odd. That gives 12 strobes per extended superframe and none in D4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bit_en | input | 1 | One-cycle enable per DS1 bit period |
| esf_mode | input | 1 | 1 selects the 24-frame superframe, 0 the 12-frame superframe |
| tx_sf_n | input | 1 | Active-low realignment request; its falling edge acts |
| rx_sync_valid | input | 1 | Receiver synchronized; gates sf_start_pulse |
| bit_index | output | 8 | Bit position within the frame, 0 to 192 |
| frame_index | output | 5 | Frame number within the superframe, from 1 |
| frame_strobe | output | 1 | 8 kHz strobe on the framing-bit position |
| sf_start_pulse | output | 1 | Announces that the next frame is frame 1 |
| fdl_strobe | output | 1 | 4 kHz data-link bit strobe in extended mode |

## Verification
A bit counter that skips or repeats a position changes the spacing between frame strobes, so the fault is visible within one 193-enable frame. A wrong frame count, a wrongly latched mode or a lost realignment request moves the superframe-start pulse or the frame index. That shows up within one superframe, at most 4632 bit enables. A parity slip in the frame count moves the data-link strobes to even frames, which is seen at the first extended-mode frame.

// File: rtl/ds1_tim_pkg.sv
// Package: shared sizes for the DS1 timing generator.
// Assumes the frame length fits BIT_W bits and the longest superframe fits FRM_W bits.
package ds1_tim_pkg;
    localparam int unsigned BITS_PER_FRAME = 193;
    localparam int unsigned FRAMES_D4      = 12;
    localparam int unsigned FRAMES_ESF     = 24;
    localparam int unsigned BIT_W          = $clog2(BITS_PER_FRAME);
    localparam int unsigned FRM_W          = $clog2(FRAMES_ESF + 1);
endpackage

// File: rtl/ds1_bit_ctr.sv
// Module: bit position counter within one DS1 frame.
// Counts bit enables from 0 to BITS_PER_FRAME-1 and flags the last bit.
// Assumes bit_en is a single-cycle pulse per line bit.
module ds1_bit_ctr
    import ds1_tim_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_en,
    output logic [BIT_W-1:0] bit_index,
    output logic             frame_wrap
);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(BITS_PER_FRAME - 1);

    logic [BIT_W-1:0] idx_q;

    // last enabled bit of the frame
    assign frame_wrap = bit_en && (idx_q == LAST_BIT);
    assign bit_index  = idx_q;

    // advance the bit position on each enable
    always_ff @(posedge clk) begin
        if (!rst_n)
            idx_q <= '0;
        else if (frame_wrap)
            idx_q <= '0;
        else if (bit_en)
            idx_q <= idx_q + 1'b1;
    end

    a_r2_bit_range: assert property (@(posedge clk) disable iff (!rst_n)
        idx_q <= LAST_BIT);
    a_r2_bit_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> $stable(idx_q));
    a_r2_bit_step: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && idx_q != LAST_BIT) |=> idx_q == $past(idx_q) + 1'b1);
endmodule

// File: rtl/ds1_realign_det.sv
// Module: falling-edge detector on the active-low realignment input.
// Produces a one-cycle request per high-to-low transition.
// Assumes tx_sf_n is already synchronous to clk.
module ds1_realign_det (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_sf_n,
    output logic realign_fall
);
    logic prev_q;

    // remember last level; reset as idle-high
    always_ff @(posedge clk) begin
        if (!rst_n)
            prev_q <= 1'b1;
        else
            prev_q <= tx_sf_n;
    end

    assign realign_fall = prev_q && !tx_sf_n;

    a_r8_single_edge: assert property (@(posedge clk) disable iff (!rst_n)
        realign_fall |=> !realign_fall);
endmodule

// File: rtl/ds1_sf_ctr.sv
// Module: frame counter within a superframe, with mode latch and realignment.
// The length (12 or 24) is latched at each restart to frame 1.
// A realignment request stays pending until the next frame boundary.
module ds1_sf_ctr
    import ds1_tim_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_wrap,
    input  logic             esf_mode,
    input  logic             realign_fall,
    output logic [FRM_W-1:0] frame_index,
    output logic             esf_active,
    output logic             restart
);
    localparam logic [FRM_W-1:0] LEN_D4  = FRM_W'(FRAMES_D4);
    localparam logic [FRM_W-1:0] LEN_ESF = FRM_W'(FRAMES_ESF);
    localparam logic [FRM_W-1:0] FIRST   = FRM_W'(1);

    logic [FRM_W-1:0] frm_q;
    logic             esf_q;
    logic             pend_q;
    logic [FRM_W-1:0] len;

    assign len         = esf_q ? LEN_ESF : LEN_D4;
    // next frame is frame 1: length reached or realignment requested
    assign restart     = pend_q || realign_fall || (frm_q >= len);
    assign frame_index = frm_q;
    assign esf_active  = esf_q;

    // frame number and mode latch, updated at frame boundaries
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frm_q <= FIRST;
            esf_q <= 1'b0;
        end else if (frame_wrap) begin
            if (restart) begin
                frm_q <= FIRST;
                esf_q <= esf_mode;
            end else begin
                frm_q <= frm_q + 1'b1;
            end
        end
    end

    // hold a realignment request until it is consumed at a boundary
    always_ff @(posedge clk) begin
        if (!rst_n)
            pend_q <= 1'b0;
        else if (frame_wrap)
            pend_q <= 1'b0;
        else if (realign_fall)
            pend_q <= 1'b1;
    end

    a_r3_frame_range: assert property (@(posedge clk) disable iff (!rst_n)
        frm_q >= FIRST && frm_q <= len);
    a_r8_realign_first: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_wrap && realign_fall) |=> frm_q == FIRST);
    a_r5_mode_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_wrap |=> $stable(esf_q));
endmodule

// File: rtl/ds1_frame_timer.sv
// Module: DS1 frame and superframe timing generator (top).
// Combines the bit counter, the realignment detector and the frame counter,
// and derives the frame, superframe-start and data-link strobes.
// Assumes all inputs are synchronous to clk.
module ds1_frame_timer
    import ds1_tim_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_en,
    input  logic             esf_mode,
    input  logic             tx_sf_n,
    input  logic             rx_sync_valid,
    output logic [BIT_W-1:0] bit_index,
    output logic [FRM_W-1:0] frame_index,
    output logic             frame_strobe,
    output logic             sf_start_pulse,
    output logic             fdl_strobe
);
    logic frame_wrap;
    logic realign_fall;
    logic esf_active;
    logic restart;

    ds1_bit_ctr u_bit (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_en     (bit_en),
        .bit_index  (bit_index),
        .frame_wrap (frame_wrap)
    );

    ds1_realign_det u_realign (
        .clk          (clk),
        .rst_n        (rst_n),
        .tx_sf_n      (tx_sf_n),
        .realign_fall (realign_fall)
    );

    ds1_sf_ctr u_sf (
        .clk          (clk),
        .rst_n        (rst_n),
        .frame_wrap   (frame_wrap),
        .esf_mode     (esf_mode),
        .realign_fall (realign_fall),
        .frame_index  (frame_index),
        .esf_active   (esf_active),
        .restart      (restart)
    );

    // strobes from the current counter state
    assign frame_strobe   = bit_en && (bit_index == '0);
    assign fdl_strobe     = frame_strobe && esf_active && frame_index[0];
    assign sf_start_pulse = frame_wrap && restart && rx_sync_valid;

    a_r7_sync_gate: assert property (@(posedge clk) disable iff (!rst_n)
        sf_start_pulse |-> rx_sync_valid);
    a_r6_sf_then_first: assert property (@(posedge clk) disable iff (!rst_n)
        sf_start_pulse |=> (frame_index == FRM_W'(1) && bit_index == '0));
    a_r9_fdl_odd: assert property (@(posedge clk) disable iff (!rst_n)
        fdl_strobe |-> (frame_index[0] && frame_strobe));
endmodule

// File: tb/tb_ds1_frame_timer.sv
module tb_ds1_frame_timer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_en = 1'b0;
    logic       esf_mode = 1'b0;
    logic       tx_sf_n = 1'b1;
    logic       rx_sync_valid = 1'b1;
    logic [7:0] bit_index;
    logic [4:0] frame_index;
    logic       frame_strobe, sf_start_pulse, fdl_strobe;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    logic s_fs, s_sf, s_fdl;
    int   s_fi, s_bi;

    ds1_frame_timer dut (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .esf_mode(esf_mode),
        .tx_sf_n(tx_sf_n), .rx_sync_valid(rx_sync_valid),
        .bit_index(bit_index), .frame_index(frame_index),
        .frame_strobe(frame_strobe), .sf_start_pulse(sf_start_pulse),
        .fdl_strobe(fdl_strobe)
    );

    always #4 clk = ~clk;

    // watchdog
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog: actual=%0d cycles expected=<150000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // one bit period: enable for one cycle, sample state before the update
    task automatic one_bit();
        @(negedge clk);
        bit_en = 1'b1;
        #1;
        s_fs = frame_strobe; s_sf = sf_start_pulse; s_fdl = fdl_strobe;
        s_fi = int'(frame_index); s_bi = int'(bit_index);
        @(negedge clk);
        bit_en = 1'b0;
    endtask

    // run until a superframe-start pulse is sampled
    task automatic wait_sf(output int bits, output int frames, output int fdls, output int bad);
        bits = 0; frames = 0; fdls = 0; bad = 0;
        do begin
            one_bit();
            bits++;
            if (s_fs) frames++;
            if (s_fdl) begin
                fdls++;
                if (s_fi % 2 == 0) bad++;
            end
        end while (!s_sf && bits < 6000);
    endtask

    task automatic t_reset();
        @(negedge clk); #1;
        chk(bit_index == 0, "R1 bit_index", int'(bit_index), 0);
        chk(frame_index == 1, "R1 frame_index", int'(frame_index), 1);
        chk(!frame_strobe && !sf_start_pulse && !fdl_strobe, "R1 strobes",
            int'({frame_strobe, sf_start_pulse, fdl_strobe}), 0);
    endtask

    task automatic t_frame_period();
        int n;
        int maxbi;
        do one_bit(); while (!s_fs);
        n = 0; maxbi = 0;
        do begin
            one_bit();
            n++;
            if (s_bi > maxbi) maxbi = s_bi;
        end while (!s_fs);
        chk(n == 193, "R2 frame period", n, 193);
        chk(maxbi == 192, "R2 max bit_index", maxbi, 192);
    endtask

    task automatic t_d4();
        int b, f, d, x;
        wait_sf(b, f, d, x);
        wait_sf(b, f, d, x);
        chk(b == 2316, "R3 D4 superframe bits", b, 2316);
        chk(f == 12, "R3 D4 frames", f, 12);
        chk(s_fi == 12 && s_bi == 192, "R6 pulse position", s_fi * 1000 + s_bi, 12192);
        chk(d == 0, "R9 no fdl in D4", d, 0);
    endtask

    task automatic t_mode_esf();
        int b, f, d, x;
        esf_mode = 1'b1;   // changed just after a boundary
        wait_sf(b, f, d, x);
        chk(f == 12, "R5 current superframe keeps D4", f, 12);
        wait_sf(b, f, d, x);
        chk(b == 4632, "R4 ESF superframe bits", b, 4632);
        chk(f == 24, "R4 ESF frames", f, 24);
        chk(d == 12, "R9 fdl count", d, 12);
        chk(x == 0, "R9 fdl only odd frames", x, 0);
    endtask

    task automatic t_mode_d4_mid();
        int b, f, d, x;
        do one_bit(); while (s_fi != 15);
        esf_mode = 1'b0;
        wait_sf(b, f, d, x);
        chk(s_fi == 24, "R5 mid change waits for boundary", s_fi, 24);
        wait_sf(b, f, d, x);
        chk(f == 12, "R5 new D4 length", f, 12);
    endtask

    task automatic t_realign();
        int sfs;
        int b, f, d, x;
        do one_bit(); while (!(s_fi == 5 && s_bi == 50));
        tx_sf_n = 1'b0;
        sfs = 0;
        for (int i = 0; i < 150; i++) begin one_bit(); if (s_sf) sfs++; end
        chk(s_fi == 1 && s_bi == 7, "R8 realigned to frame 1", s_fi * 1000 + s_bi, 1007);
        chk(sfs == 1, "R6 pulse before realigned frame", sfs, 1);
        for (int i = 0; i < 200; i++) one_bit();
        chk(s_fi == 2 && s_bi == 14, "R8 single realignment", s_fi * 1000 + s_bi, 2014);
        tx_sf_n = 1'b1;
        wait_sf(b, f, d, x);
        chk(s_fi == 12, "R3 free run after realign", s_fi, 12);
    endtask

    task automatic t_nosync();
        int sfs;
        int wraps;
        rx_sync_valid = 1'b0;
        sfs = 0; wraps = 0;
        for (int i = 0; i < 4632; i++) begin
            one_bit();
            if (s_sf) sfs++;
            if (s_fi == 1 && s_bi == 0) wraps++;
        end
        chk(sfs == 0, "R7 no pulse unsynchronized", sfs, 0);
        chk(wraps == 2, "R7 counters keep wrapping", wraps, 2);
        rx_sync_valid = 1'b1;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_frame_period();
        t_d4();
        t_mode_esf();
        t_mode_d4_mid();
        t_realign();
        t_nosync();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule